// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block decides when the core clock runs and when execution continues after a power-down. It runs from the oscillator clock and drives a system clock enable. A prescale-select input chooses between two rates. In the divided rate the enable is high on every second oscillator cycle. In the bypass rate the enable is high on every cycle. A change of rate is applied only at the end of a divided period, so a divided period that has started is never cut short.

A one-cycle power-down request stops the clock enable. The block then watches an active-low external interrupt line, brought in through a parameterised synchroniser. One of two wake rules applies, set by the wake-mode input. In edge mode the block wakes when the line is released, which is its rising edge. In delay mode the block wakes a fixed interval after the line is asserted, which is its falling edge. That interval is counted in oscillator cycles and derived from the oscillator frequency. A new falling edge during the count starts the count again. When the block wakes it emits a one-cycle resume strobe and the clock enable runs again.

Top module: `pd_wake_seq`

## Requirements
- R1: After reset the block is running in the divided rate. Resume is 0. The clock enable is 0 in the first cycle after reset and 1 in the next cycle.
- R2: When cfg_nodiv = 0 (divided rate), the clock enable is high on every second oscillator cycle and never on two cycles in a row.
- R3: When cfg_nodiv = 1 (bypass rate), the clock enable is high on every cycle. A change of cfg_nodiv takes effect only at an edge that ends a cycle in which the enable was high, or while the clock is stopped.
- R4: A pd_req sampled high while running stops the clock enable from the next cycle. The enable stays 0 until resume fires.
- R5: With cfg_edge_wake = 1 (edge mode), resume goes high in the cycle that follows the (SYNC_STAGES+1)-th clock edge after irq_n rises from 0 to 1.
- R6: With cfg_edge_wake = 0 (delay mode), a falling edge of irq_n is accepted at the (SYNC_STAGES+1)-th clock edge after it. Resume goes high after a further TERM edges, where TERM = (OSC_HZ/1000)*DELAY_US/1000.
- R7: In delay mode, a falling edge of irq_n accepted while the count is running restarts the count from zero.
- R8: Resume is a single-cycle pulse and fires only when the block is leaving power-down. The clock enable follows the selected rate again from the resume cycle.
- R9: Edges of irq_n that the active rule does not use have no effect. These are falling edges in edge mode, rising edges in delay mode, and any edge while running. None of them produces a resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_req | input | 1 | Power-down request, sampled while running |
| irq_n | input | 1 | External interrupt line, active low, asynchronous |
| cfg_nodiv | input | 1 | 0: divide the oscillator by two, 1: bypass the divider |
| cfg_edge_wake | input | 1 | 1: wake on the rising edge of irq_n, 0: wake after the delay that starts at its falling edge |
| sys_clk_en | output | 1 | System clock enable |
| resume | output | 1 | One-cycle strobe when execution resumes |

## Verification
The main function is tried with a table of sleep episodes. The table varies the wake mode, how long the interrupt line is held low, and whether a second falling edge arrives in the middle of the count. Short and long pulses in edge mode tell a rise-triggered wake apart from a level-triggered one. In delay mode, a pulse shorter than the delay and a pulse longer than it show that only the falling edge and the counter decide the wake time. Late re-falls show that the count restarts rather than continues. Directed tests count enable pulses in both rates, hold the line low in edge mode so that a falling edge alone must not wake the block, and toggle the line while running.

// File: rtl/pd_wake_pkg.sv
`timescale 1ns/1ps
package pd_wake_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_COUNT = 2'd2
   } pd_state_e;
endpackage

// File: rtl/pd_irq_edge.sv
`timescale 1ns/1ps
module pd_irq_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_n,
   output logic rise_o,
   output logic fall_o
);
   logic irq_s;
   logic prev_q;

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("pd_irq_edge: SYNC_STAGES must be 0..4");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign irq_s = irq_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q, irq_n};
         end
         assign irq_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= irq_s;
   end

   assign rise_o = irq_s & ~prev_q;
   assign fall_o = ~irq_s & prev_q;
endmodule

// File: rtl/pd_clk_prescaler.sv
`timescale 1ns/1ps
module pd_clk_prescaler (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic nodiv_i,
   output logic en_o
);
   logic mode_q;
   logic phase_q;
   logic boundary;

   // A rate change is applied only where a divided period ends, or while stopped
   assign boundary = ~run_i | mode_q | phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= 1'b0;
         phase_q <= 1'b0;
      end else begin
         if (boundary) mode_q <= nodiv_i;
         if (!run_i || mode_q) phase_q <= 1'b0;
         else                  phase_q <= ~phase_q;
      end
   end

   assign en_o = run_i & (mode_q | phase_q);

   p_div_no_back2back_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && !mode_q && !nodiv_i) |=> !en_o);

   p_mode_on_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> $past(en_o || !run_i));
endmodule

// File: rtl/pd_wake_timer.sv
`timescale 1ns/1ps
module pd_wake_timer #(
   parameter int TERM = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);
   localparam int CW = $clog2(TERM + 1);

   logic [CW-1:0] cnt_q;
   logic          running_q;

   initial begin
      if (TERM < 2) $error("pd_wake_timer: TERM must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
      end else if (start_i) begin
         cnt_q     <= '0;
         running_q <= 1'b1;
      end else if (running_q) begin
         if (cnt_q == CW'(TERM - 1)) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign done_o = running_q & ~start_i & (cnt_q == CW'(TERM - 1));

   p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(TERM));

   p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (cnt_q == '0 && running_q));
endmodule

// File: rtl/pd_wake_seq.sv
`timescale 1ns/1ps
module pd_wake_seq
   import pd_wake_pkg::*;
#(
   parameter int OSC_HZ      = 24_000_000,
   parameter int DELAY_US    = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic pd_req,
   input  logic irq_n,
   input  logic cfg_nodiv,
   input  logic cfg_edge_wake,
   output logic sys_clk_en,
   output logic resume
);
   localparam int TERM = (OSC_HZ / 1000) * DELAY_US / 1000;

   pd_state_e state_q, state_d;
   logic      resume_q, resume_d;
   logic      start;
   logic      rise, fall, done;

   initial begin
      if (OSC_HZ < 1000) $error("pd_wake_seq: OSC_HZ too small");
      if (DELAY_US < 1)  $error("pd_wake_seq: DELAY_US must be positive");
   end

   pd_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(osc_clk), .rst_n(rst_n), .irq_n(irq_n), .rise_o(rise), .fall_o(fall)
   );

   pd_wake_timer #(.TERM(TERM)) u_timer (
      .clk(osc_clk), .rst_n(rst_n), .start_i(start), .done_o(done)
   );

   pd_clk_prescaler u_presc (
      .clk(osc_clk), .rst_n(rst_n), .run_i(state_q == ST_RUN),
      .nodiv_i(cfg_nodiv), .en_o(sys_clk_en)
   );

   always_comb begin
      state_d  = state_q;
      resume_d = 1'b0;
      start    = 1'b0;
      unique case (state_q)
         ST_RUN:   if (pd_req) state_d = ST_SLEEP;
         ST_SLEEP: begin
            if (cfg_edge_wake && rise) begin
               state_d  = ST_RUN;
               resume_d = 1'b1;
            end else if (!cfg_edge_wake && fall) begin
               state_d = ST_COUNT;
               start   = 1'b1;
            end
         end
         ST_COUNT: begin
            if (fall) begin
               start = 1'b1;
            end else if (done) begin
               state_d  = ST_RUN;
               resume_d = 1'b1;
            end
         end
         default:  state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RUN;
         resume_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         resume_q <= resume_d;
      end
   end

   assign resume = resume_q;

   p_en_low_asleep_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (state_q != ST_RUN) |-> !sys_clk_en);

   p_resume_single_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
      resume |=> !resume);

   p_resume_from_sleep_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
      resume |-> ($past(state_q) != ST_RUN && state_q == ST_RUN));

   p_no_wake_in_run_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (state_q == ST_RUN) |=> !resume);
endmodule

// File: tb/pd_wake_seq_bench.sv
`timescale 1ns/1ps
module pd_wake_seq_bench;
   localparam int OSC_HZ = 1_000_000;
   localparam int DLY_US = 12;
   localparam int SYNC   = 2;
   localparam int TERM   = 12;  // (OSC_HZ/1000)*DLY_US/1000
   localparam int LAT    = SYNC + 1;

   // fields: [31:24] edge mode, [23:16] cycles low, [15:8] re-fall cycle (0 none), [7:0] expected resume cycle
   localparam logic [31:0] WAKE_VEC [7] = '{
      {8'd1, 8'd4,  8'd0,  8'd7},    // edge, rise after 4 -> 4+3
      {8'd1, 8'd1,  8'd0,  8'd4},    // edge, 1-cycle pulse
      {8'd1, 8'd9,  8'd0,  8'd12},   // edge, long pulse
      {8'd0, 8'd4,  8'd0,  8'd15},   // delay, 3+12
      {8'd0, 8'd20, 8'd0,  8'd15},   // delay, still low at wake
      {8'd0, 8'd2,  8'd6,  8'd21},   // delay, restart at 6 -> 6+15
      {8'd0, 8'd2,  8'd10, 8'd25}    // delay, restart at 10 -> 10+15
   };

   logic osc_clk = 1'b0;
   logic rst_n = 1'b0, pd_req = 1'b0, irq_n = 1'b1, cfg_nodiv = 1'b0, cfg_edge_wake = 1'b0;
   logic sys_clk_en, resume;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;

   always #2.5 osc_clk = ~osc_clk;

   pd_wake_seq #(.OSC_HZ(OSC_HZ), .DELAY_US(DLY_US), .SYNC_STAGES(SYNC)) u_pd_wake_seq (
      .osc_clk(osc_clk), .rst_n(rst_n), .pd_req(pd_req), .irq_n(irq_n),
      .cfg_nodiv(cfg_nodiv), .cfg_edge_wake(cfg_edge_wake),
      .sys_clk_en(sys_clk_en), .resume(resume)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge osc_clk);
      @(negedge osc_clk);
   endtask

   task automatic count_en(input int n, output int hits, output int pairs);
      hits = 0; pairs = 0;
      for (int i = 0; i < n; i++) begin
         logic prev;
         prev = sys_clk_en;
         step();
         if (sys_clk_en) hits++;
         if (sys_clk_en && prev) pairs++;
      end
   endtask

   task automatic go_sleep();
      pd_req = 1'b1;
      step();
      pd_req = 1'b0;
      chk("R4 enable off after request", int'(sys_clk_en), 0);
      for (int i = 0; i < 4; i++) step();
      chk("R4 enable stays off asleep", int'(sys_clk_en), 0);
   endtask

   task automatic run_wake(input logic [31:0] v);
      int low, regap, exp, got, en_seen;
      low = int'(v[23:16]); regap = int'(v[15:8]); exp = int'(v[7:0]);
      cfg_edge_wake = v[24];
      go_sleep();
      irq_n = 1'b0;
      got = -1; en_seen = 0;
      for (int k = 1; k < 80; k++) begin
         step();
         if (resume) begin got = k; break; end
         if (sys_clk_en) en_seen++;
         if (k == low) irq_n = 1'b1;
         if (regap != 0 && k == regap) irq_n = 1'b0;
      end
      if (v[24]) chk("R5 edge-mode resume cycle", got, exp);
      else if (regap != 0) chk("R7 restarted delay resume cycle", got, exp);
      else chk("R6 delay-mode resume cycle", got, exp);
      chk("R4 enable low until resume", en_seen, 0);
      step();
      chk("R8 resume single cycle", int'(resume), 0);
      irq_n = 1'b1;
      for (int i = 0; i < 6; i++) step();
      chk("R9 no resume from edges while running", int'(resume), 0);
   endtask

   initial begin
      int hits, pairs, got;
      repeat (3) @(negedge osc_clk);
      rst_n = 1'b1;
      chk("R1 resume after reset", int'(resume), 0);
      chk("R1 enable first cycle", int'(sys_clk_en), 0);
      step();
      chk("R1 enable second cycle", int'(sys_clk_en), 1);

      count_en(20, hits, pairs);
      chk("R2 divided enable count", hits, 10);
      chk("R2 no back-to-back enables", pairs, 0);

      cfg_nodiv = 1'b1;
      step(); step();
      count_en(20, hits, pairs);
      chk("R3 bypass enable count", hits, 20);
      cfg_nodiv = 1'b0;
      step();
      chk("R3 switch to divided, first cycle low", int'(sys_clk_en), 0);
      step();
      chk("R3 switch to divided, second cycle high", int'(sys_clk_en), 1);

      for (int i = 0; i < 7; i++) run_wake(WAKE_VEC[i]);

      // R9: falling edge alone must not wake in edge mode
      cfg_edge_wake = 1'b1;
      go_sleep();
      irq_n = 1'b0;
      got = 0;
      for (int i = 0; i < 30; i++) begin step(); if (resume) got++; end
      chk("R9 edge mode ignores falling edge", got, 0);
      irq_n = 1'b1;
      got = -1;
      for (int k = 1; k < 10; k++) begin step(); if (resume) begin got = k; break; end end
      chk("R5 wake after held-low release", got, LAT);

      // R8: bypass rate enable back on in resume cycle
      cfg_nodiv = 1'b1;
      step(); step();
      cfg_edge_wake = 1'b0;
      go_sleep();
      irq_n = 1'b0;
      got = -1;
      for (int k = 1; k < 40; k++) begin step(); if (resume) begin got = k; break; end end
      chk("R6 delay wake in bypass rate", got, LAT + TERM);
      chk("R8 enable on in resume cycle", int'(sys_clk_en), 1);
      irq_n = 1'b1;
      step();
      chk("R8 enable stays on after resume", int'(sys_clk_en), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge osc_clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule